// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a memory device. A sixteen-state controller follows TMS on every rising edge of TCK and moves serial data between TDI and TDO through one of four registers: a 3-bit instruction register, a 32-bit identification register, a one-bit bypass stage and a boundary register whose length is a parameter. Besides the serial output and its enable, the block tells the device core two things. One signal says the pins must be driven from the boundary register's update stage. The other says every data output must float.

Eight instruction codes exist. External test drives the pins from the boundary register. Sampling captures the pin states, and shifting new data in never reaches the pins. A floating-sample instruction captures the pins while all outputs float. The remaining codes select the identification register or the bypass stage. The three unassigned codes act as bypass. The reset state loads the identification instruction, and the test port is reset through a synchronous active-high reset clocked by TCK.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While reset is applied and right after it, tdo_en, bsr_drive and pins_hiz are 0 and bsr_out is all zeros.
- R2: The Test-Logic-Reset state loads the identification instruction (code 001), so a data scan taken after reset returns the 32-bit identification word, least significant bit first.
- R3: In the Capture-IR state the instruction shift stage is loaded with 001, so the first three TDO bits of an instruction scan are 1, 0, 0.
- R4: The identification word is {version[3:0], part[15:0], vendor[10:0], 1'b1}; bit 0 is always 1.
- R5: Code 111 places a single stage between TDI and TDO; it captures 0, so a data scan of N bits returns 0 followed by the first N-1 TDI bits.
- R6: Codes 011, 101 and 110 behave exactly as code 111.
- R7: Codes 000, 010 and 100 capture pin_in into the boundary register in Capture-DR; the boundary register shifts from TDI at its top bit towards TDO at bit 0.
- R8: Under code 100 (sample) shifting and Update-DR leave bsr_out unchanged and bsr_drive stays 0.
- R9: Under code 000 (external test) Update-DR copies the boundary shift stage to bsr_out, and bsr_drive is 1 while the code is selected.
- R10: pins_hiz is 1 exactly while code 010 (floating sample) is selected, and then bsr_drive is 0.
- R11: tdo_en is 1 only while the controller is in Shift-DR or Shift-IR.
- R12: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state.
- R13: TDO changes only on the falling edge of TCK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, sampled on TCK edges |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| pin_in | input | BSR_LEN | Pin states seen by the boundary cells |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for tdo |
| bsr_out | output | BSR_LEN | Boundary update stage, drives pins under external test |
| bsr_drive | output | 1 | Core must drive its pins from bsr_out |
| pins_hiz | output | 1 | Core must float all data outputs |

## Verification
The bench builds the block with a 10-cell boundary register and an identification word of version 3, part A51B and vendor 02C. The short chain lets every boundary scan run end to end with a distinct pattern, so bit order and the one-cycle bypass delay are both visible. The non-zero, asymmetric identification fields expose any swap of field order or a missing bit 0 marker.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET    = 4'hF,
        ST_IDLE     = 4'hC,
        ST_SEL_DR   = 4'h7,
        ST_CAP_DR   = 4'h6,
        ST_SH_DR    = 4'h2,
        ST_EX1_DR   = 4'h1,
        ST_PAUSE_DR = 4'h3,
        ST_EX2_DR   = 4'h0,
        ST_UPD_DR   = 4'h5,
        ST_SEL_IR   = 4'h4,
        ST_CAP_IR   = 4'hE,
        ST_SH_IR    = 4'hA,
        ST_EX1_IR   = 4'h9,
        ST_PAUSE_IR = 4'hB,
        ST_EX2_IR   = 4'h8,
        ST_UPD_IR   = 4'hD
    } tap_state_t;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST      = 3'b000,
        OP_IDCODE      = 3'b001,
        OP_SAMPLE_HIZ  = 3'b010,
        OP_SPARE_A     = 3'b011,
        OP_SAMPLE      = 3'b100,
        OP_SPARE_B     = 3'b101,
        OP_SPARE_C     = 3'b110,
        OP_BYPASS      = 3'b111
    } tap_op_t;

    typedef struct packed {
        logic sel_bsr;
        logic sel_id;
        logic sel_byp;
        logic drive;
        logic hiz;
    } op_dec_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic m);
        case (s)
            ST_RESET:    return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:     return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR:   return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR:   return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:    return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR:   return m ? ST_UPD_DR : ST_PAUSE_DR;
            ST_PAUSE_DR: return m ? ST_EX2_DR : ST_PAUSE_DR;
            ST_EX2_DR:   return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR:   return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR:   return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:    return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR:   return m ? ST_UPD_IR : ST_PAUSE_IR;
            ST_PAUSE_IR: return m ? ST_EX2_IR : ST_PAUSE_IR;
            ST_EX2_IR:   return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR:   return m ? ST_SEL_DR : ST_IDLE;
            default:     return ST_RESET;
        endcase
    endfunction

    function automatic op_dec_t op_decode(tap_op_t op);
        op_dec_t d;
        d = '0;
        case (op)
            OP_EXTEST:     begin d.sel_bsr = 1'b1; d.drive = 1'b1; end
            OP_SAMPLE_HIZ: begin d.sel_bsr = 1'b1; d.hiz = 1'b1; end
            OP_SAMPLE:     d.sel_bsr = 1'b1;
            OP_IDCODE:     d.sel_id = 1'b1;
            default:       d.sel_byp = 1'b1;
        endcase
        return d;
    endfunction

    function automatic logic [ID_W-1:0] make_id(logic [3:0] ver, logic [15:0] part,
                                                 logic [10:0] vend);
        return {ver, part, vend, 1'b1};
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    // run of consecutive high TMS samples, saturating at five
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (rst || !tms)      ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    assert_five_ones_reset_R12: assert property (@(posedge tck) disable iff (rst)
        (ones_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_t state,
    output tap_op_t    op,
    output logic       ir_lsb
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sh <= IR_CAPTURE;
            op    <= OP_IDCODE;
        end else begin
            case (state)
                ST_CAP_IR: ir_sh <= IR_CAPTURE;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                default:   ir_sh <= ir_sh;
            endcase
            if (state == ST_RESET)       op <= OP_IDCODE;
            else if (state == ST_UPD_IR) op <= tap_op_t'(ir_sh);
        end
    end

    assign ir_lsb = ir_sh[0];

    assert_ir_capture_R3: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

    assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET) |=> (op == OP_IDCODE));

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              BSR_LEN  = 16,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tdi,
    input  tap_state_t         state,
    input  tap_op_t            op,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               bsr_drive,
    output logic               pins_hiz
);

    op_dec_t dec;
    assign dec = op_decode(op);

    logic               byp;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_sh;

    always_ff @(posedge tck) begin
        if (rst) begin
            byp     <= 1'b0;
            id_sh   <= ID_VALUE;
            bsr_sh  <= '0;
            bsr_out <= '0;
        end else begin
            if (state == ST_CAP_DR) begin
                if (dec.sel_byp) byp    <= 1'b0;
                if (dec.sel_id)  id_sh  <= ID_VALUE;
                if (dec.sel_bsr) bsr_sh <= pin_in;
            end
            if (state == ST_SH_DR) begin
                if (dec.sel_byp) byp    <= tdi;
                if (dec.sel_id)  id_sh  <= {tdi, id_sh[ID_W-1:1]};
                if (dec.sel_bsr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
            end
            // only external test lets shifted data reach the pins
            if (state == ST_UPD_DR && dec.drive) bsr_out <= bsr_sh;
        end
    end

    always_comb begin
        if (dec.sel_id)       dr_lsb = id_sh[0];
        else if (dec.sel_bsr) dr_lsb = bsr_sh[0];
        else                  dr_lsb = byp;
    end

    assign bsr_drive = dec.drive;
    assign pins_hiz  = dec.hiz;

    assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_DR && dec.sel_byp) |=> (byp == 1'b0));

    assert_id_marker_R4: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_DR && dec.sel_id) |=> id_sh[0]);

    assert_preload_inert_R8: assert property (@(posedge tck) disable iff (rst)
        (state == ST_UPD_DR && op != OP_EXTEST) |=> $stable(bsr_out));

endmodule

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN   = 16,
    parameter logic [3:0]  ID_VER    = 4'h1,
    parameter logic [15:0] ID_PART   = 16'h0100,
    parameter logic [10:0] ID_VENDOR = 11'h001
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bsr_out,
    output logic               bsr_drive,
    output logic               pins_hiz
);

    localparam logic [ID_W-1:0] ID_VALUE = make_id(ID_VER, ID_PART, ID_VENDOR);

    tap_state_t state;
    tap_op_t    op;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       shifting;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state),
        .op     (op),
        .ir_lsb (ir_lsb)
    );

    scan_tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (state),
        .op        (op),
        .pin_in    (pin_in),
        .dr_lsb    (dr_lsb),
        .bsr_out   (bsr_out),
        .bsr_drive (bsr_drive),
        .pins_hiz  (pins_hiz)
    );

    assign shifting = (state == ST_SH_DR) || (state == ST_SH_IR);

    // serial output launched half a cycle ahead of the capturing edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shifting;
            tdo    <= (state == ST_SH_IR) ? ir_lsb : dr_lsb;
        end
    end

    assert_tdo_en_shift_R11: assert property (@(posedge tck) disable iff (rst)
        tdo_en == shifting);

    assert_hiz_no_drive_R10: assert property (@(posedge tck) disable iff (rst)
        pins_hiz |-> !bsr_drive);

endmodule

// File: tb/sim_scan_tap_ctrl.sv
`timescale 1ns/1ps
module sim_scan_tap_ctrl;

    localparam int BL = 10;
    localparam logic [31:0] ID_EXP = 32'h3A51_B059;

    logic          tck = 1'b0;
    logic          rst = 1'b1;
    logic          tms = 1'b1;
    logic          tdi = 1'b1;
    logic [BL-1:0] pin_in = '0;
    logic          tdo, tdo_en, bsr_drive, pins_hiz;
    logic [BL-1:0] bsr_out;

    int checks = 0;
    int errors = 0;
    int glitch = 0;
    int en_bad = 0;

    always #2 tck = ~tck;

    scan_tap_ctrl #(
        .BSR_LEN   (BL),
        .ID_VER    (4'h3),
        .ID_PART   (16'hA51B),
        .ID_VENDOR (11'h02C)
    ) u0 (
        .tck (tck), .rst (rst), .tms (tms), .tdi (tdi), .pin_in (pin_in),
        .tdo (tdo), .tdo_en (tdo_en), .bsr_out (bsr_out),
        .bsr_drive (bsr_drive), .pins_hiz (pins_hiz)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one TCK cycle: inputs set after the falling edge, TDO sampled before the rising edge
    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #0.5;
        tms = m;
        tdi = d;
        #1;
        o = tdo;
        e = tdo_en;
        @(posedge tck);
        #0.5;
        if (tdo !== o) glitch++;
    endtask

    task automatic go_idle();
        logic o, e;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o, e;
        step(1'b1, 1'b0, o, e);
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o, e);
            cap[i] = o;
            if (e !== 1'b1) en_bad++;
        end
        step(1'b1, 1'b0, o, e);
        if (e !== 1'b0) en_bad++;
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, e;
        dout = '0;
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        if (e !== 1'b0) en_bad++;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            if (e !== 1'b1) en_bad++;
        end
        step(1'b1, 1'b0, o, e);
        if (e !== 1'b0) en_bad++;
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic t_reset();
        check("R1 tdo_en", {63'd0, tdo_en}, 64'd0);
        check("R1 bsr_drive", {63'd0, bsr_drive}, 64'd0);
        check("R1 pins_hiz", {63'd0, pins_hiz}, 64'd0);
        check("R1 bsr_out", {54'd0, bsr_out}, 64'd0);
    endtask

    task automatic t_idcode();
        logic [63:0] q;
        go_idle();
        scan_dr(32, 64'h0, q);
        check("R2 id after reset", q, {32'd0, ID_EXP});
        check("R4 id bit0", {63'd0, q[0]}, 64'd1);
    endtask

    task automatic t_ir_capture();
        logic [2:0] cap;
        load_ir(3'b111, cap);
        check("R3 capture pattern", {61'd0, cap}, 64'd1);
    endtask

    task automatic t_bypass();
        logic [63:0] q;
        logic [2:0]  cap;
        load_ir(3'b111, cap);
        scan_dr(8, 64'hB5, q);
        check("R5 bypass", q, (64'hB5 << 1) & 64'hFF);
    endtask

    task automatic t_spare();
        logic [63:0] q;
        logic [2:0]  cap;
        logic [2:0]  codes [3];
        codes[0] = 3'b011; codes[1] = 3'b101; codes[2] = 3'b110;
        for (int k = 0; k < 3; k++) begin
            load_ir(codes[k], cap);
            scan_dr(6, 64'h2D, q);
            check($sformatf("R6 spare code %b", codes[k]), q, (64'h2D << 1) & 64'h3F);
            check("R6 no drive", {62'd0, bsr_drive, pins_hiz}, 64'd0);
        end
    endtask

    task automatic t_extest();
        logic [63:0] q;
        logic [2:0]  cap;
        pin_in = 10'h0F3;
        load_ir(3'b000, cap);
        check("R9 drive selected", {63'd0, bsr_drive}, 64'd1);
        scan_dr(BL, 64'h3A6, q);
        check("R7 extest capture", q, 64'h0F3);
        check("R9 update", {54'd0, bsr_out}, 64'h3A6);
        check("R10 no hiz under extest", {63'd0, pins_hiz}, 64'd0);
    endtask

    task automatic t_sample();
        logic [63:0] q;
        logic [2:0]  cap;
        pin_in = 10'h2C7;
        load_ir(3'b100, cap);
        scan_dr(BL, 64'h155, q);
        check("R7 sample capture", q, 64'h2C7);
        check("R8 preload inert", {54'd0, bsr_out}, 64'h3A6);
        check("R8 no drive", {63'd0, bsr_drive}, 64'd0);
    endtask

    task automatic t_sample_hiz();
        logic [63:0] q;
        logic [2:0]  cap;
        pin_in = 10'h1E1;
        load_ir(3'b010, cap);
        check("R10 hiz selected", {62'd0, pins_hiz, bsr_drive}, 64'd2);
        scan_dr(BL, 64'h0CC, q);
        check("R10 hiz capture", q, 64'h1E1);
        check("R10 bsr_out kept", {54'd0, bsr_out}, 64'h3A6);
    endtask

    task automatic t_five_ones();
        logic o, e;
        logic [63:0] q;
        step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
        check("R12 hiz released", {63'd0, pins_hiz}, 64'd0);
        scan_dr(32, 64'h0, q);
        check("R12 id reselected", q, {32'd0, ID_EXP});
    endtask

    task automatic t_enable_edges();
        check("R11 enable only in shift", en_bad, 0);
        check("R11 idle enable", {63'd0, tdo_en}, 64'd0);
        check("R13 tdo stable at rising edge", glitch, 0);
    endtask

    initial begin
        repeat (4) @(posedge tck);
        #0.5;
        t_reset();
        @(negedge tck);
        rst = 1'b0;
        t_idcode();
        t_ir_capture();
        t_bypass();
        t_spare();
        t_extest();
        t_sample();
        t_sample_hiz();
        t_five_ones();
        t_enable_edges();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule